// File: doc/BRIEF.md
# Processor Bus Cycle Controller

This block runs the external bus cycles of a small 8-bit processor with a 16-bit address space. The core hands it one request at a time, naming the cycle kind (opcode fetch, memory read, memory write, I/O read or I/O write) together with an address and, for writes, a data byte. The controller then walks through its T-states. It puts the address on the bus, drives the proper active-low strobe and holds it, samples the wait input to stretch the cycle, and latches the read data on the last edge of the cycle. It then reports completion to the core with a single-clock pulse.

The no-wait length of a machine cycle is set by `BASE_T`, which is 3 or 4 T-states. When `DIV2_EN` is set, every T-state lasts two input clocks instead of one. Memory and I/O have separate read and write strobes. A separate fetch indicator marks opcode fetches, so they can be told apart from plain memory reads.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: During reset all four strobes, `fetch_no` and `req_ready_o` are high, and `done_o` and `bus_wdata_oe_o` are low.
- R2: A request is taken on a rising edge where `req_valid_i` is high, `req_ready_o` is high and `req_kind_i` is a legal code. `req_ready_o` is low from the next clock until the clock that carries `done_o`.
- R3: With no waits, a cycle occupies exactly `BASE_T` T-states, and each T-state is 1 clock (or 2 clocks when `DIV2_EN`=1). The first T-state (T1) starts in the clock after acceptance.
- R4: `bus_addr_o` carries the request address from T1 onward and does not change while any strobe is low.
- R5: Kind codes are 0 fetch, 1 memory read, 2 memory write, 3 I/O read and 4 I/O write. For codes 0 and 1, `mem_rd_no` is low in every clock from T1 to the final T-state. For code 3, `io_rd_no` is low over the same span. At most one strobe is low at any time.
- R6: For codes 2 and 4, `bus_wdata_oe_o` is high and `bus_wdata_o` holds the request data from T1 to the final T-state. `mem_wr_no` (code 2) or `io_wr_no` (code 4) is low from T2 to the final T-state.
- R7: `fetch_no` is low in exactly the clocks of a code-0 cycle, always together with `mem_rd_no`.
- R8: If `wait_i` is high on the last rising edge of a T2 state, one more T2 follows. The cycle grows by one T-state per wait, and the address and strobes are held.
- R9: For read kinds (0, 1 and 3), `bus_rdata_i` is latched on the final edge of the cycle and appears on `rdata_o` alongside `done_o`. It is held until the next read completes. Write cycles leave `rdata_o` unchanged.
- R10: `done_o` is high for one clock, the clock after the final T-state, and all strobes are high in that clock.
- R11: A request with kind code 5, 6 or 7 is ignored: no strobe falls, `req_ready_o` stays high and `done_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Core presents a cycle request |
| req_kind_i | input | 3 | Cycle kind code (see R5) |
| req_addr_i | input | ADDR_W | Cycle address |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DATA_W | Data from the last read cycle |
| bus_addr_o | output | ADDR_W | External address bus |
| bus_wdata_o | output | DATA_W | External write data |
| bus_wdata_oe_o | output | 1 | Write data drive enable |
| bus_rdata_i | input | DATA_W | External read data |
| wait_i | input | 1 | Wait request, active high |
| mem_rd_no | output | 1 | Memory read strobe, active low |
| mem_wr_no | output | 1 | Memory write strobe, active low |
| io_rd_no | output | 1 | I/O read strobe, active low |
| io_wr_no | output | 1 | I/O write strobe, active low |
| fetch_no | output | 1 | Opcode fetch marker, active low |

## Verification
Counting from the accepting edge, strobes, address and write data are due in the very next clock. `done_o` and the new `rdata_o` are due one clock after `(BASE_T + waits) * DIV` clocks of strobe activity, where DIV is 1 or 2. A wait counts only if `wait_i` is high on the last edge of a T2. The bench keeps a behavioural model per configuration that advances an elapsed-clock count on each rising edge. It compares every output with that model on each falling edge, so that every result is checked in the clock it is due. Directed checks count strobe-low clocks for zero-wait and wait-stretched reads in two configurations (3 T-states with no divider, 4 T-states with the divider), and they watch that illegal codes leave the ports untouched.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  typedef enum logic [2:0] {
    KIND_FETCH = 3'd0,
    KIND_MRD   = 3'd1,
    KIND_MWR   = 3'd2,
    KIND_IORD  = 3'd3,
    KIND_IOWR  = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4
  } tstate_e;

  function automatic logic kind_legal(logic [2:0] k);
    return k <= 3'd4;
  endfunction

  function automatic logic kind_read(logic [2:0] k);
    return (k == KIND_FETCH) || (k == KIND_MRD) || (k == KIND_IORD);
  endfunction

  function automatic logic kind_write(logic [2:0] k);
    return (k == KIND_MWR) || (k == KIND_IOWR);
  endfunction

  function automatic logic kind_io(logic [2:0] k);
    return (k == KIND_IORD) || (k == KIND_IOWR);
  endfunction

endpackage

// File: rtl/bcc_tick.sv
// T-state pacing: t_end_o marks the last input clock of the current T-state.
module bcc_tick #(
  parameter bit DIV2_EN = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic t_end_o
);

  generate
    if (DIV2_EN) begin : g_div2
      logic phase_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     phase_q <= 1'b0;
        else if (!run_i) phase_q <= 1'b0;
        else             phase_q <= ~phase_q;
      end
      assign t_end_o = run_i & phase_q;
    end else begin : g_div1
      assign t_end_o = run_i;
    end
  endgenerate

endmodule

// File: rtl/bcc_seq.sv
module bcc_seq
  import bcc_pkg::*;
#(
  parameter int BASE_T = 3
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    t_end_i,
  input  logic    wait_i,
  output tstate_e state_o,
  output logic    finish_o,
  output logic    done_o
);

  localparam bit FOUR_T = (BASE_T == 4);
  localparam tstate_e LAST_TS = FOUR_T ? TS_T4 : TS_T3;

  tstate_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TS_IDLE: if (start_i) state_d = TS_T1;
      TS_T1:   if (t_end_i) state_d = TS_T2;
      TS_T2:   if (t_end_i && !wait_i) state_d = TS_T3;  // wait repeats T2
      TS_T3:   if (t_end_i) state_d = FOUR_T ? TS_T4 : TS_IDLE;
      TS_T4:   if (t_end_i) state_d = TS_IDLE;
      default: state_d = TS_IDLE;
    endcase
  end

  assign finish_o = t_end_i && (state_q == LAST_TS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TS_IDLE;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= finish_o;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/bcc_pins.sv
module bcc_pins
  import bcc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              finish_i,
  input  tstate_e           state_i,
  input  logic [2:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_wdata_oe_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_rd_no,
  output logic              mem_wr_no,
  output logic              io_rd_no,
  output logic              io_wr_no,
  output logic              fetch_no
);

  logic [2:0]        kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q  <= 3'd0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start_i) begin
      kind_q  <= kind_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  // capture on the last edge, while the read strobe is still low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           rdata_q <= '0;
    else if (finish_i && kind_read(kind_q)) rdata_q <= bus_rdata_i;
  end

  logic active, rd_on, wr_on, io_sel;

  always_comb begin
    active = (state_i != TS_IDLE);
    io_sel = kind_io(kind_q);
    rd_on  = active && kind_read(kind_q);
    wr_on  = active && (state_i != TS_T1) && kind_write(kind_q);
  end

  assign mem_rd_no      = ~(rd_on & ~io_sel);
  assign io_rd_no       = ~(rd_on &  io_sel);
  assign mem_wr_no      = ~(wr_on & ~io_sel);
  assign io_wr_no       = ~(wr_on &  io_sel);
  assign fetch_no       = ~(active && (kind_q == KIND_FETCH));
  assign bus_wdata_oe_o = active && kind_write(kind_q);
  assign bus_wdata_o    = wdata_q;
  assign bus_addr_o     = addr_q;
  assign rdata_o        = rdata_q;

endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl
  import bcc_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int BASE_T  = 3,
  parameter bit DIV2_EN = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_wdata_oe_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              wait_i,
  output logic              mem_rd_no,
  output logic              mem_wr_no,
  output logic              io_rd_no,
  output logic              io_wr_no,
  output logic              fetch_no
);

  tstate_e state;
  logic    t_end, finish, start, run;

  assign run         = (state != TS_IDLE);
  assign req_ready_o = ~run;
  assign start       = req_valid_i && req_ready_o && kind_legal(req_kind_i);

  bcc_tick #(.DIV2_EN(DIV2_EN)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .t_end_o(t_end)
  );

  bcc_seq #(.BASE_T(BASE_T)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .t_end_i (t_end),
    .wait_i  (wait_i),
    .state_o (state),
    .finish_o(finish),
    .done_o  (done_o)
  );

  bcc_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start),
    .finish_i      (finish),
    .state_i       (state),
    .kind_i        (req_kind_i),
    .addr_i        (req_addr_i),
    .wdata_i       (req_wdata_i),
    .bus_rdata_i   (bus_rdata_i),
    .bus_addr_o    (bus_addr_o),
    .bus_wdata_o   (bus_wdata_o),
    .bus_wdata_oe_o(bus_wdata_oe_o),
    .rdata_o       (rdata_o),
    .mem_rd_no     (mem_rd_no),
    .mem_wr_no     (mem_wr_no),
    .io_rd_no      (io_rd_no),
    .io_wr_no      (io_wr_no),
    .fetch_no      (fetch_no)
  );

endmodule

// File: rtl/bcc_checker.sv
module bcc_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [2:0]        req_kind_i,
  input logic              req_ready_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_wdata_oe_o,
  input logic              mem_rd_no,
  input logic              mem_wr_no,
  input logic              io_rd_no,
  input logic              io_wr_no,
  input logic              fetch_no
);

  logic any_strb;
  assign any_strb = ~(mem_rd_no & mem_wr_no & io_rd_no & io_wr_no);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (!any_strb && req_ready_o && !done_o && fetch_no);
    end
  end

  assert_take_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_kind_i <= 3'd4) |=> !req_ready_o);

  assert_addr_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_strb && $past(any_strb)) |-> $stable(bus_addr_o));

  assert_one_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~mem_rd_no, ~mem_wr_no, ~io_rd_no, ~io_wr_no}) <= 1);

  assert_wr_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_wr_no || !io_wr_no) |-> bus_wdata_oe_o);

  assert_fetch_mem_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_no |-> !mem_rd_no);

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_release_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!any_strb && fetch_no && !bus_wdata_oe_o));

  assert_ignore_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_kind_i > 3'd4) |=> (req_ready_o && !any_strb));

endmodule

bind bus_cycle_ctrl bcc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_kind_i    (req_kind_i),
  .req_ready_o   (req_ready_o),
  .done_o        (done_o),
  .bus_addr_o    (bus_addr_o),
  .bus_wdata_oe_o(bus_wdata_oe_o),
  .mem_rd_no     (mem_rd_no),
  .mem_wr_no     (mem_wr_no),
  .io_rd_no      (io_rd_no),
  .io_wr_no      (io_wr_no),
  .fetch_no      (fetch_no)
);

// File: tb/sim_bus_cycle_ctrl.sv
module sim_bus_ref #(
  parameter int BASE_T = 3,
  parameter int DIV    = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        valid,
  input logic [2:0]  kind,
  input logic [15:0] addr,
  input logic [7:0]  wdata,
  input logic        wait_in,
  input logic        ready,
  input logic        done,
  input logic [7:0]  rdata,
  input logic [15:0] baddr,
  input logic [7:0]  bwdata,
  input logic        boe,
  input logic        mrd_n,
  input logic        mwr_n,
  input logic        iord_n,
  input logic        iowr_n,
  input logic        fet_n
);

  int checks = 0;
  int errors = 0;

  bit        m_busy, m_done;
  int        e, w, m_len, busy_cnt;
  bit [2:0]  m_kind;
  bit [15:0] m_addr;
  bit [7:0]  m_wdata, m_rdata;

  function automatic bit [7:0] mem_val(bit [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cfg T=%0d div=%0d act=%0h exp=%0h at %0t", tag, BASE_T, DIV, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; e = 0; w = 0; m_len = 0;
      m_kind = 0; m_addr = 0; m_wdata = 0; m_rdata = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (valid && kind <= 3'd4) begin
          m_busy = 1; e = 0; w = 0;
          m_kind = kind; m_addr = addr; m_wdata = wdata;
        end
      end else begin
        if ((e % DIV) == DIV - 1 && (e / DIV) == w + 1 && wait_in) w++;
        e++;
        if (e == (BASE_T + w) * DIV) begin
          m_busy = 0; m_done = 1; m_len = e;
          if (m_kind == 0 || m_kind == 1 || m_kind == 3) m_rdata = mem_val(m_addr);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit rd_m, rd_io, wr_m, wr_io, wr;
      int k;
      k     = e / DIV;
      rd_m  = m_busy && (m_kind == 0 || m_kind == 1);
      rd_io = m_busy && m_kind == 3;
      wr    = m_busy && (m_kind == 2 || m_kind == 4);
      wr_m  = m_busy && m_kind == 2 && k >= 1;
      wr_io = m_busy && m_kind == 4 && k >= 1;
      chk(ready == !m_busy, "R2 ready", ready, !m_busy);
      chk(mrd_n == !rd_m, "R5 mem_rd", mrd_n, !rd_m);
      chk(iord_n == !rd_io, "R5 io_rd", iord_n, !rd_io);
      chk(mwr_n == !wr_m, "R6 mem_wr", mwr_n, !wr_m);
      chk(iowr_n == !wr_io, "R6 io_wr", iowr_n, !wr_io);
      chk(boe == wr, "R6 oe", boe, wr);
      if (wr) chk(bwdata == m_wdata, "R6 wdata", bwdata, m_wdata);
      chk(fet_n == !(m_busy && m_kind == 0), "R7 fetch", fet_n, !(m_busy && m_kind == 0));
      if (m_busy) chk(baddr == m_addr, "R4 addr", baddr, m_addr);
      chk(done == m_done, "R10 done", done, m_done);
      chk(rdata == m_rdata, "R9 rdata", rdata, m_rdata);
      if (done) begin
        chk(busy_cnt == m_len, "R3 R8 cycle length", busy_cnt, m_len);
        busy_cnt = 0;
      end else if (!ready) busy_cnt++;
    end else busy_cnt = 0;
  end

endmodule

module sim_bus_cycle_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        valid = 1'b0;
  logic [2:0]  kind = 3'd0;
  logic [15:0] addr = 16'd0;
  logic [7:0]  wdata = 8'd0;
  logic        wait_in = 1'b0;

  int checks = 0;
  int errors = 0;
  int low0 = 0, low1 = 0;
  bit finished = 0;

  logic        rdy0, done0, oe0, mrd0, mwr0, iord0, iowr0, fet0;
  logic [7:0]  rdata0, wd0, brd0;
  logic [15:0] ba0;
  logic        rdy1, done1, oe1, mrd1, mwr1, iord1, iowr1, fet1;
  logic [7:0]  rdata1, wd1, brd1;
  logic [15:0] ba1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] mem_val(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign brd0 = (!mrd0 || !iord0) ? mem_val(ba0) : 8'h00;
  assign brd1 = (!mrd1 || !iord1) ? mem_val(ba1) : 8'h00;

  bus_cycle_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_kind_i(kind),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_ready_o(rdy0), .done_o(done0),
    .rdata_o(rdata0), .bus_addr_o(ba0), .bus_wdata_o(wd0), .bus_wdata_oe_o(oe0),
    .bus_rdata_i(brd0), .wait_i(wait_in), .mem_rd_no(mrd0), .mem_wr_no(mwr0),
    .io_rd_no(iord0), .io_wr_no(iowr0), .fetch_no(fet0)
  );

  bus_cycle_ctrl #(.BASE_T(4), .DIV2_EN(1'b1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_kind_i(kind),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_ready_o(rdy1), .done_o(done1),
    .rdata_o(rdata1), .bus_addr_o(ba1), .bus_wdata_o(wd1), .bus_wdata_oe_o(oe1),
    .bus_rdata_i(brd1), .wait_i(wait_in), .mem_rd_no(mrd1), .mem_wr_no(mwr1),
    .io_rd_no(iord1), .io_wr_no(iowr1), .fetch_no(fet1)
  );

  sim_bus_ref #(.BASE_T(3), .DIV(1)) r0 (
    .clk(clk), .rst_n(rst_n), .valid(valid), .kind(kind), .addr(addr), .wdata(wdata),
    .wait_in(wait_in), .ready(rdy0), .done(done0), .rdata(rdata0), .baddr(ba0),
    .bwdata(wd0), .boe(oe0), .mrd_n(mrd0), .mwr_n(mwr0), .iord_n(iord0),
    .iowr_n(iowr0), .fet_n(fet0)
  );

  sim_bus_ref #(.BASE_T(4), .DIV(2)) r1 (
    .clk(clk), .rst_n(rst_n), .valid(valid), .kind(kind), .addr(addr), .wdata(wdata),
    .wait_in(wait_in), .ready(rdy1), .done(done1), .rdata(rdata1), .baddr(ba1),
    .bwdata(wd1), .boe(oe1), .mrd_n(mrd1), .mwr_n(mwr1), .iord_n(iord1),
    .iowr_n(iowr1), .fet_n(fet1)
  );

  always @(negedge clk) begin
    if (!(mrd0 && mwr0 && iord0 && iowr0)) low0++;
    if (!(mrd1 && mwr1 && iord1 && iowr1)) low1++;
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks + r0.checks + r1.checks,
               errors + r0.errors + r1.errors);
      $finish;
    end
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(rdy0 && rdy1));
  endtask

  // one-clock request pulse; waits hold wait_in high for wclk negedges after it
  task automatic issue(logic [2:0] k, logic [15:0] a, logic [7:0] d, int wclk);
    wait_idle();
    kind = k; addr = a; wdata = d; valid = 1'b1;
    low0 = 0; low1 = 0;
    @(negedge clk);
    valid = 1'b0;
    if (wclk > 0) begin
      wait_in = 1'b1;
      repeat (wclk) @(negedge clk);
      wait_in = 1'b0;
    end
    wait_idle();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mrd0 && mwr0 && iord0 && iowr0 && mrd1 && mwr1 && iord1 && iowr1, "R1 strobes high", 0, 1);
    chk(rdy0 && rdy1 && fet0 && fet1, "R1 ready/fetch high", {rdy0, rdy1, fet0, fet1}, 4'hF);
    chk(!done0 && !done1 && !oe0 && !oe1, "R1 done/oe low", {done0, done1, oe0, oe1}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 zero-wait read length: 3 clocks (u0), 4 T-states x 2 clocks (u1)
    issue(3'd1, 16'h8001, 8'h00, 0);
    chk(low0 == 3, "R3 u0 strobe clocks", low0, 3);
    chk(low1 == 8, "R3 u1 strobe clocks", low1, 8);
    // R9 captured data
    chk(rdata0 == mem_val(16'h8001), "R9 u0 rdata", rdata0, mem_val(16'h8001));
    chk(rdata1 == mem_val(16'h8001), "R9 u1 rdata", rdata1, mem_val(16'h8001));

    // R8 wait high on edges A+1..A+3: u0 gets 2 waits, u1 none
    issue(3'd0, 16'h0100, 8'h00, 3);
    chk(low0 == 5, "R8 u0 stretched clocks", low0, 5);
    chk(low1 == 8, "R8 u1 unaffected clocks", low1, 8);

    // R8 long wait stretches u1 too
    issue(3'd3, 16'h0012, 8'h00, 6);
    chk(low1 > 8, "R8 u1 stretched", low1, 9);

    // R6 writes, rdata held (R9)
    issue(3'd2, 16'h4000, 8'hA5, 0);
    chk(rdata0 == mem_val(16'h0012), "R9 held over write", rdata0, mem_val(16'h0012));
    issue(3'd4, 16'h00FE, 8'h3C, 2);

    // R11 illegal codes ignored
    for (int c = 5; c < 8; c++) begin
      wait_idle();
      kind = c[2:0]; addr = 16'hDEAD; valid = 1'b1;
      @(negedge clk);
      valid = 1'b0;
      chk(rdy0 && rdy1, "R11 still ready", {rdy0, rdy1}, 3);
      chk(mrd0 && mwr0 && iord0 && iowr0 && fet0, "R11 no strobe", 0, 1);
      @(negedge clk);
      chk(!done0 && !done1, "R11 no done", {done0, done1}, 0);
    end

    // mixed traffic
    for (int i = 0; i < 60; i++) begin
      issue(3'(i % 5), 16'(i * 16'h1357 + 7), 8'(i * 29), (i % 4 == 3) ? (i % 7) : 0);
    end

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule